// File: doc/BRIEF.md
# Chunking SPI Register-Access Master

This block performs register reads and writes on a remote device over a four-wire SPI link, on behalf of a local host. The host presents one request: a direction, a starting 32-bit word address and a byte length. The block cuts the request into frames. Each frame is a 32-bit command word followed by up to 64 payload words. Chip select is held low for the whole of one frame.

For a write, payload words are pulled from a FIFO-style source: the current head word is always presented, and a pop strobe consumes it. For a read, each word shifted in from MISO is offered on a valid/ready output. The engine stalls between words until the host accepts the word. The link runs in SPI mode 0, with the bit rate set by a fixed clock divider.

The block also produces three one-cycle strobes. A timestamp strobe marks the point of each frame where the remote side latches time-related state. A done strobe ends an accepted request. An error strobe rejects a malformed one.

Top module: `spi_chunk_master`

## Requirements
- R1: Every frame opens with a 32-bit command word shifted MSB first. Bit 31 gives the direction (1 write, 0 read). Bits 24..4 give the frame's starting word address. Bits 3..0 are zero.
- R2: In a write frame, command bits 30..25 are all zero.
- R3: In a read frame, command bits 30..25 hold the frame's payload word count modulo 64, so a full 64-word read frame sends 0 there.
- R4: A request of N words produces ceil(N/64) frames. Every frame except the last carries 64 payload words, and the last carries the remainder.
- R5: Each frame's address equals the previous frame's address plus the previous frame's word count. Across the request, payload word i belongs to address start+i.
- R6: cs_n is low from the first command bit to the last payload bit of a frame. It goes high after every frame, stays high for at least 2*HALF_CLKS*GAP_SCLKS clock cycles between frames of one request, and sclk is low whenever cs_n is high.
- R7: SPI mode 0 timing applies. sclk idles low, mosi changes only while sclk is low, and miso is sampled on the rising sclk edge. Payload words travel MSB first.
- R8: Each write payload word is taken from wr_data, in order, with exactly one wr_pop per word. wr_pop occurs only while cs_n is low.
- R9: Each read word is presented on rd_data with rd_valid. The word and the valid flag hold until rd_ready, and no further bit is shifted while a word waits.
- R10: ts_strobe is a one-cycle pulse, exactly once per frame. In a read frame it follows the last command bit. In a write frame it follows the last payload bit.
- R11: A request whose byte length is zero or not a multiple of 4 gives a one-cycle err pulse. It drives no cs_n activity and gives no done.
- R12: done is a one-cycle pulse issued as cs_n rises after the final frame. req_ready is high exactly when the block is idle and can accept a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_ready | output | 1 | High while idle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | ADDR_W | Starting word address |
| req_len | input | LEN_W | Request length in bytes |
| wr_data | input | 32 | Head word of the host write source |
| wr_pop | output | 1 | Consumes wr_data at this clock edge |
| rd_data | output | 32 | Read word |
| rd_valid | output | 1 | rd_data holds an unaccepted word |
| rd_ready | input | 1 | Host accepts rd_data |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | SPI data to the device |
| cs_n | output | 1 | SPI chip select, active low |
| miso | input | 1 | SPI data from the device |
| ts_strobe | output | 1 | Per-frame timestamp event |
| done | output | 1 | Request complete |
| err | output | 1 | Request rejected |

## Verification
The bench aims at the chunk boundary cases. A 65-word write forces a one-word tail frame. A 128-word read produces two full frames whose count field wraps to 0. A design that miscounted would show a wrong frame length, a count field of 64 truncated into the address, or a second-frame address that did not advance by 64. A read under a stalling rd_ready checks that no bits are lost or repeated while a word waits. Illegal lengths must leave chip select untouched. The timestamp is placed by counting SCLK edges inside the frame, so a strobe raised on the wrong side of the payload is caught.

// File: rtl/spi_chunk_pkg.sv
package spi_chunk_pkg;

   localparam int unsigned WORD_BITS  = 32;
   localparam int unsigned CNT_BITS   = 6;
   localparam int unsigned ADDR_FIELD = 21;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_HDR,
      ST_PAY,
      ST_RDWAIT,
      ST_NEXT,
      ST_GAP
   } xfer_state_t;

   // command word: direction, count, address, four zero bits
   function automatic logic [WORD_BITS-1:0] make_header(
      input logic                  is_write,
      input logic [CNT_BITS-1:0]   cnt,
      input logic [ADDR_FIELD-1:0] addr
   );
      logic [CNT_BITS-1:0] cfield;
      cfield = is_write ? '0 : cnt;
      return {is_write, cfield, addr, 4'b0000};
   endfunction

endpackage

// File: rtl/spi_chunk_planner.sv
module spi_chunk_planner #(
   parameter int unsigned ADDR_W    = 21,
   parameter int unsigned WORDS_W   = 10,
   parameter int unsigned MAX_WORDS = 64
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [ADDR_W-1:0]    load_addr,
   input  logic [WORDS_W-1:0]   load_words,
   input  logic                 advance,
   output logic [ADDR_W-1:0]    cur_addr,
   output logic [$clog2(MAX_WORDS+1)-1:0] chunk_words,
   output logic                 last_chunk
);
   localparam int unsigned CHUNK_W = $clog2(MAX_WORDS + 1);

   logic [ADDR_W-1:0]  addr_q;
   logic [WORDS_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         rem_q  <= '0;
      end else if (load) begin
         addr_q <= load_addr;
         rem_q  <= load_words;
      end else if (advance) begin
         addr_q <= addr_q + ADDR_W'(chunk_words);
         rem_q  <= rem_q - WORDS_W'(chunk_words);
      end
   end

   always_comb begin
      if (rem_q > WORDS_W'(MAX_WORDS)) begin
         chunk_words = CHUNK_W'(MAX_WORDS);
         last_chunk  = 1'b0;
      end else begin
         chunk_words = rem_q[CHUNK_W-1:0];
         last_chunk  = 1'b1;
      end
   end

   assign cur_addr = addr_q;

endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
   parameter int unsigned HALF_CLKS = 4,
   parameter int unsigned WORD_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi,
   output logic              done,
   output logic [WORD_W-1:0] rx_word
);
   localparam int unsigned BIT_W = $clog2(WORD_W);

   logic              busy_q;
   logic              phase_q;
   logic [BIT_W-1:0]  bit_q;
   logic [WORD_W-1:0] sr_q;
   logic [WORD_W-1:0] rx_q;
   logic              done_q;
   logic              half_tick;

   generate
      if (HALF_CLKS == 1) begin : g_nodiv
         assign half_tick = busy_q;
      end else begin : g_div
         localparam int unsigned DIV_W = $clog2(HALF_CLKS);
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               div_q <= '0;
            else if (start || !busy_q || half_tick)
               div_q <= '0;
            else
               div_q <= div_q + 1'b1;
         end
         assign half_tick = busy_q && (div_q == DIV_W'(HALF_CLKS - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         phase_q <= 1'b0;
         bit_q   <= '0;
         sr_q    <= '0;
         rx_q    <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start && !busy_q) begin
            sr_q    <= tx_word;
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            bit_q   <= '0;
         end else if (half_tick) begin
            if (!phase_q) begin
               phase_q <= 1'b1;
               rx_q    <= {rx_q[WORD_W-2:0], miso};
            end else begin
               phase_q <= 1'b0;
               sr_q    <= {sr_q[WORD_W-2:0], 1'b0};
               if (bit_q == BIT_W'(WORD_W - 1)) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
               end
            end
         end
      end
   end

   assign sclk    = busy_q & phase_q;
   assign mosi    = sr_q[WORD_W-1];
   assign done    = done_q;
   assign rx_word = rx_q;

endmodule

// File: rtl/spi_chunk_master.sv
module spi_chunk_master
   import spi_chunk_pkg::*;
#(
   parameter int unsigned ADDR_W    = 21,
   parameter int unsigned LEN_W     = 12,
   parameter int unsigned MAX_WORDS = 64,
   parameter int unsigned HALF_CLKS = 4,
   parameter int unsigned GAP_SCLKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [31:0]       wr_data,
   output logic              wr_pop,
   output logic [31:0]       rd_data,
   output logic              rd_valid,
   input  logic              rd_ready,
   output logic              sclk,
   output logic              mosi,
   output logic              cs_n,
   input  logic              miso,
   output logic              ts_strobe,
   output logic              done,
   output logic              err
);
   localparam int unsigned WORDS_W  = LEN_W - 2;
   localparam int unsigned CHUNK_W  = $clog2(MAX_WORDS + 1);
   localparam int unsigned GAP_CLKS = 2 * HALF_CLKS * GAP_SCLKS;
   localparam int unsigned GAP_W    = $clog2(GAP_CLKS + 1);

   generate
      if (HALF_CLKS < 1) begin : g_bad_half
         $error("HALF_CLKS must be at least 1");
      end
      if (GAP_SCLKS < 1) begin : g_bad_gap
         $error("GAP_SCLKS must be at least 1");
      end
      if (MAX_WORDS < 1 || MAX_WORDS > 64) begin : g_bad_max
         $error("MAX_WORDS must lie in 1..64");
      end
      if (ADDR_W > ADDR_FIELD) begin : g_bad_addr
         $error("ADDR_W exceeds the command address field");
      end
      if (WORDS_W < CHUNK_W) begin : g_bad_len
         $error("LEN_W too small for one full frame");
      end
   endgenerate

   xfer_state_t         state_q;
   logic                is_wr_q;
   logic [CHUNK_W-1:0]  idx_q;
   logic [GAP_W-1:0]    gap_q;
   logic                cs_n_q;
   logic [31:0]         rd_data_q;
   logic                rd_valid_q;
   logic                ts_q;
   logic                done_q;
   logic                err_q;

   logic [ADDR_W-1:0]   cur_addr;
   logic [CHUNK_W-1:0]  chunk_words;
   logic                last_chunk;
   logic                pl_load;
   logic                pl_adv;

   logic                sh_start;
   logic [31:0]         sh_word;
   logic                sh_done;
   logic [31:0]         sh_rx;

   logic                bad_len;
   logic                last_word;
   logic                pop_c;
   logic [31:0]         header_word;

   spi_chunk_planner #(
      .ADDR_W    (ADDR_W),
      .WORDS_W   (WORDS_W),
      .MAX_WORDS (MAX_WORDS)
   ) u_plan (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (pl_load),
      .load_addr   (req_addr),
      .load_words  (req_len[LEN_W-1:2]),
      .advance     (pl_adv),
      .cur_addr    (cur_addr),
      .chunk_words (chunk_words),
      .last_chunk  (last_chunk)
   );

   spi_word_shifter #(
      .HALF_CLKS (HALF_CLKS),
      .WORD_W    (WORD_BITS)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (sh_start),
      .tx_word (sh_word),
      .miso    (miso),
      .sclk    (sclk),
      .mosi    (mosi),
      .done    (sh_done),
      .rx_word (sh_rx)
   );

   assign bad_len     = (req_len[1:0] != 2'b00) || (req_len == '0);
   assign last_word   = ((idx_q + 1'b1) == chunk_words);
   assign header_word = make_header(is_wr_q, CNT_BITS'(chunk_words),
                                    ADDR_FIELD'(cur_addr));

   always_comb begin
      sh_start = 1'b0;
      sh_word  = header_word;
      pop_c    = 1'b0;
      pl_load  = 1'b0;
      pl_adv   = 1'b0;
      case (state_q)
         ST_IDLE:  pl_load = req_valid && !bad_len;
         ST_START: sh_start = 1'b1;
         ST_HDR: begin
            if (sh_done) begin
               sh_start = 1'b1;
               sh_word  = is_wr_q ? wr_data : '0;
               pop_c    = is_wr_q;
            end
         end
         ST_NEXT: begin
            if (!last_word) begin
               sh_start = 1'b1;
               sh_word  = is_wr_q ? wr_data : '0;
               pop_c    = is_wr_q;
            end else if (!last_chunk) begin
               pl_adv = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         is_wr_q    <= 1'b0;
         idx_q      <= '0;
         gap_q      <= '0;
         cs_n_q     <= 1'b1;
         rd_data_q  <= '0;
         rd_valid_q <= 1'b0;
         ts_q       <= 1'b0;
         done_q     <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         ts_q   <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (bad_len) begin
                     err_q <= 1'b1;
                  end else begin
                     is_wr_q <= req_write;
                     state_q <= ST_START;
                  end
               end
            end
            ST_START: begin
               cs_n_q  <= 1'b0;
               state_q <= ST_HDR;
            end
            ST_HDR: begin
               if (sh_done) begin
                  idx_q   <= '0;
                  state_q <= ST_PAY;
                  if (!is_wr_q) ts_q <= 1'b1;
               end
            end
            ST_PAY: begin
               if (sh_done) begin
                  if (is_wr_q) begin
                     state_q <= ST_NEXT;
                     if (last_word) ts_q <= 1'b1;
                  end else begin
                     rd_data_q  <= sh_rx;
                     rd_valid_q <= 1'b1;
                     state_q    <= ST_RDWAIT;
                  end
               end
            end
            ST_RDWAIT: begin
               if (rd_ready) begin
                  rd_valid_q <= 1'b0;
                  state_q    <= ST_NEXT;
               end
            end
            ST_NEXT: begin
               if (!last_word) begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= ST_PAY;
               end else begin
                  cs_n_q <= 1'b1;
                  if (last_chunk) begin
                     done_q  <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     gap_q   <= '0;
                     state_q <= ST_GAP;
                  end
               end
            end
            ST_GAP: begin
               if (gap_q == GAP_W'(GAP_CLKS - 1))
                  state_q <= ST_START;
               else
                  gap_q <= gap_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign wr_pop    = pop_c;
   assign rd_data   = rd_data_q;
   assign rd_valid  = rd_valid_q;
   assign cs_n      = cs_n_q;
   assign ts_strobe = ts_q;
   assign done      = done_q;
   assign err       = err_q;

endmodule

// File: rtl/spi_chunk_master_chk.sv
module spi_chunk_master_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_ready,
   input logic        wr_pop,
   input logic [31:0] rd_data,
   input logic        rd_valid,
   input logic        rd_ready,
   input logic        sclk,
   input logic        mosi,
   input logic        cs_n,
   input logic        ts_strobe,
   input logic        done,
   input logic        err
);
   a_r6_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   a_r7_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> (mosi == $past(mosi)));

   a_r8_pop_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pop |-> !cs_n);

   a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

   a_r10_ts_single: assert property (@(posedge clk) disable iff (!rst_n)
      ts_strobe |=> !ts_strobe);

   a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (cs_n && !done));

   a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && req_ready));

endmodule

bind spi_chunk_master spi_chunk_master_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .wr_pop    (wr_pop),
   .rd_data   (rd_data),
   .rd_valid  (rd_valid),
   .rd_ready  (rd_ready),
   .sclk      (sclk),
   .mosi      (mosi),
   .cs_n      (cs_n),
   .ts_strobe (ts_strobe),
   .done      (done),
   .err       (err)
);

// File: tb/spi_chunk_master_tb.sv
module spi_chunk_master_tb;
   localparam int HALF     = 2;
   localparam int GAPS     = 2;
   localparam int GAP_CLKS = 2 * HALF * GAPS;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [20:0] req_addr = '0;
   logic [11:0] req_len = '0;
   logic [31:0] wr_data = '0;
   logic        wr_pop;
   logic [31:0] rd_data;
   logic        rd_valid;
   logic        rd_ready = 1'b1;
   logic        sclk, mosi, cs_n;
   logic        miso = 1'b0;
   logic        ts_strobe, done, err;

   always #5 clk = ~clk;

   spi_chunk_master #(
      .ADDR_W(21), .LEN_W(12), .MAX_WORDS(64), .HALF_CLKS(HALF), .GAP_SCLKS(GAPS)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
      .wr_data(wr_data), .wr_pop(wr_pop), .rd_data(rd_data), .rd_valid(rd_valid),
      .rd_ready(rd_ready), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso),
      .ts_strobe(ts_strobe), .done(done), .err(err)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rd_word(input int a);
      logic [31:0] av;
      av = a;
      return {av[15:0] ^ 16'h5A3C, ~av[15:0]};
   endfunction

   // reference model state
   logic [31:0] exp_hdr[$];
   int          exp_flen[$];
   int          exp_ts[$];
   logic [31:0] exp_wr[$];
   logic [31:0] exp_rd[$];
   logic [31:0] wr_fifo[$];

   bit          bp = 1'b0;
   int          cyc = 0;
   int          bitcnt = 0;
   logic [31:0] hdr_sh = '0;
   logic [31:0] pay_sh = '0;
   int          cur_addr = 0;
   bit          cur_wr = 1'b0;
   bit          prev_cs = 1'b1;
   bit          prev_sclk = 1'b0;
   bit          prev_mosi = 1'b0;
   bit          prev_rdv = 1'b0;
   bit          prev_rdy = 1'b0;
   logic [31:0] prev_rdd = '0;
   bit          pop_flag = 1'b0;
   bit          gap_active = 1'b0;
   int          gap_cnt = 0;
   int          frames_seen = 0;
   int          ts_seen = 0;
   int          pops = 0;
   int          cs_falls = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (cs_n && sclk) chk(0, "R6", "sclk high while cs_n high", 1, 0);
         if (sclk && prev_sclk && (mosi != prev_mosi))
            chk(0, "R7", "mosi moved during sclk high", mosi, prev_mosi);

         if (!cs_n && prev_cs) begin
            cs_falls++;
            if (gap_active)
               chk(gap_cnt >= GAP_CLKS, "R6", "inter-frame gap", gap_cnt, GAP_CLKS);
            bitcnt = 0;
         end
         if (cs_n && !prev_cs) begin
            frames_seen++;
            if (exp_flen.size() > 0)
               chk(bitcnt == exp_flen.pop_front(), "R4", "frame bit length", bitcnt, 0);
            else
               chk(0, "R4", "unexpected frame", bitcnt, 0);
            gap_cnt = 0;
            gap_active = 1'b1;
         end
         if (cs_n) gap_cnt++;

         if (!cs_n && sclk && !prev_sclk) begin
            if (bitcnt < 32) hdr_sh = {hdr_sh[30:0], mosi};
            else             pay_sh = {pay_sh[30:0], mosi};
            bitcnt++;
            if (bitcnt == 32) begin
               if (exp_hdr.size() > 0) begin
                  logic [31:0] e;
                  e = exp_hdr.pop_front();
                  chk(hdr_sh == e, "R1 R2 R3 R5", "command word", hdr_sh, e);
               end else chk(0, "R1", "unexpected command", hdr_sh, 0);
               cur_addr = int'(hdr_sh[24:4]);
               cur_wr   = hdr_sh[31];
            end else if (bitcnt > 32 && (bitcnt % 32) == 0 && cur_wr) begin
               if (exp_wr.size() > 0) begin
                  logic [31:0] e;
                  e = exp_wr.pop_front();
                  chk(pay_sh == e, "R8 R7", "write payload word", pay_sh, e);
               end else chk(0, "R8", "extra write word", pay_sh, 0);
            end
         end

         if (!cs_n && bitcnt >= 32) begin
            logic [31:0] w;
            w = rd_word(cur_addr + (bitcnt - 32) / 32);
            miso = w[31 - (bitcnt % 32)];
         end else begin
            miso = 1'b0;
         end

         if (ts_strobe) begin
            ts_seen++;
            if (exp_ts.size() > 0) begin
               int e;
               e = exp_ts.pop_front();
               chk(bitcnt == e && !cs_n, "R10", "timestamp bit position", bitcnt, e);
            end else chk(0, "R10", "unexpected timestamp", bitcnt, 0);
         end

         if (prev_rdv && !prev_rdy)
            chk(rd_valid && rd_data == prev_rdd, "R9", "stalled word held", rd_data, prev_rdd);
         rd_ready = bp ? ((cyc % 3) == 0) : 1'b1;
         if (rd_valid && rd_ready) begin
            if (exp_rd.size() > 0) begin
               logic [31:0] e;
               e = exp_rd.pop_front();
               chk(rd_data == e, "R9 R5", "read word", rd_data, e);
            end else chk(0, "R9", "extra read word", rd_data, 0);
         end
         prev_rdv = rd_valid;
         prev_rdy = rd_ready;
         prev_rdd = rd_data;

         if (pop_flag && wr_fifo.size() > 0) void'(wr_fifo.pop_front());
         pop_flag = wr_pop;
         if (wr_pop) pops++;
         wr_data = (wr_fifo.size() > 0) ? wr_fifo[0] : 32'h0;

         prev_cs   = cs_n;
         prev_sclk = sclk;
         prev_mosi = mosi;
      end
   end

   task automatic run_req(input bit wr, input int addr, input int len, input bit bpm);
      int words, a, rem, nfr, c;
      words = len / 4;
      a = addr;
      rem = words;
      nfr = 0;
      bp = bpm;
      while (rem > 0) begin
         c = (rem > 64) ? 64 : rem;
         exp_hdr.push_back({wr, (wr ? 6'd0 : 6'(c)), 21'(a), 4'b0000});
         exp_flen.push_back(32 * (1 + c));
         exp_ts.push_back(wr ? 32 * (1 + c) : 32);
         a += c;
         rem -= c;
         nfr++;
      end
      for (int i = 0; i < words; i++) begin
         if (wr) begin
            logic [31:0] v;
            v = 32'hC3A5_0000 ^ (i * 32'h0001_0203) ^ addr;
            exp_wr.push_back(v);
            wr_fifo.push_back(v);
         end else begin
            exp_rd.push_back(rd_word(addr + i));
         end
      end
      @(negedge clk);
      wr_data = (wr_fifo.size() > 0) ? wr_fifo[0] : 32'h0;
      frames_seen = 0;
      ts_seen = 0;
      pops = 0;
      gap_active = 1'b0;
      chk(req_ready == 1'b1, "R12", "ready before request", req_ready, 1);
      req_write = wr;
      req_addr  = 21'(addr);
      req_len   = 12'(len);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R12", "ready dropped while busy", req_ready, 0);
      while (!done) @(negedge clk);
      chk(cs_n == 1'b1, "R12", "cs_n high at done", cs_n, 1);
      @(negedge clk);
      chk(done == 1'b0, "R12", "done is one cycle", done, 0);
      chk(req_ready == 1'b1, "R12", "ready after done", req_ready, 1);
      chk(frames_seen == nfr, "R4", "frame count", frames_seen, nfr);
      chk(ts_seen == nfr, "R10", "timestamps per request", ts_seen, nfr);
      chk(exp_hdr.size() == 0 && exp_flen.size() == 0, "R4", "frames left", exp_hdr.size(), 0);
      if (wr) begin
         chk(pops == words, "R8", "pop count", pops, words);
         chk(exp_wr.size() == 0, "R8", "write words left", exp_wr.size(), 0);
      end else begin
         chk(exp_rd.size() == 0, "R9", "read words left", exp_rd.size(), 0);
      end
      bp = 1'b0;
   endtask

   task automatic bad_req(input int len);
      int falls0;
      falls0 = cs_falls;
      @(negedge clk);
      req_write = 1'b1;
      req_len   = 12'(len);
      req_addr  = 21'h55;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(err == 1'b1, "R11", "err pulse", err, 1);
      @(negedge clk);
      chk(err == 1'b0, "R11", "err is one cycle", err, 0);
      repeat (20) begin
         @(negedge clk);
         if (!cs_n || done) chk(0, "R11", "activity after reject", {cs_n, done}, 2'b10);
      end
      chk(cs_falls == falls0, "R11", "no frame after reject", cs_falls - falls0, 0);
      chk(req_ready == 1'b1, "R11", "still idle", req_ready, 1);
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n == 1'b1 && sclk == 1'b0, "R6", "reset link idle", {cs_n, sclk}, 2'b10);
      chk(req_ready == 1'b1, "R12", "reset ready", req_ready, 1);
      chk({done, err, ts_strobe, rd_valid, wr_pop} == 5'b0, "R12", "reset strobes", {done, err, ts_strobe, rd_valid, wr_pop}, 0);

      run_req(1'b1, 32'h00123, 4, 1'b0);     // R1 R2 R8 R10 single write
      run_req(1'b0, 32'h1FFF0, 12, 1'b0);    // R3 R9 short read
      run_req(1'b1, 32'h00400, 260, 1'b0);   // R4 R5 R6 64+1 write
      run_req(1'b0, 32'h10000, 512, 1'b0);   // R3 R4 R5 two full reads, count wraps
      run_req(1'b0, 32'h00077, 20, 1'b1);    // R9 backpressure
      bad_req(6);                            // R11 unaligned
      bad_req(0);                            // R11 zero
      run_req(1'b1, 32'h0ABCD, 8, 1'b0);     // R7 R8 after rejects
      summary();
      $finish;
   end
endmodule